// File: doc/BRIEF.md
# Transform Result Dump Port Controller

This block reads a finished block of transform results out of a result memory through a strobed host port. A one-cycle `blk_ready` pulse from the transform engine raises the data-available flag, clears the read address and captures the block's 4-bit scale tag. After that, every synchronised rising edge of `out_strobe` seen while `dump_en` is high performs one internal read. The read copies the memory word at `rd_addr` into the output register and advances the address. The first strobe after data-available rises is therefore a priming (dummy) strobe. The host samples each result during the strobe that follows the one that fetched it.

Once all results have been fetched, the block is drained. One more enabled strobe hands the final result onward. What happens to data-available after that depends on the `cfg_hold_dav` control bit. When the bit is clear, data-available drops on that final strobe. When the bit is set, data-available stays high until an edge on `load_in` whose polarity is chosen by `cfg_load_rise`. The output drivers are modelled as enable signals, `bus_oe` and `tag_oe`.

All strobe-like inputs pass through a two-flop synchroniser and an edge detector. Each edge acts on the third rising clock edge after the input changes.

Top module: `dump_port_ctrl`

## Requirements
- R1: After reset, `data_avail`, `bus_oe` and `tag_oe` are 0, and `rd_addr` and `dout` are 0.
- R2: A `blk_ready` pulse while `data_avail` is 0 sets `data_avail`, sets `rd_addr` to 0 and latches `blk_tag` into `tag_out`. A `blk_ready` pulse while `data_avail` is 1 is ignored, and `tag_out` keeps its value.
- R3: `rd_addr` advances by exactly one per synchronised rising edge of `out_strobe`, and only while `dump_en` and `data_avail` are both 1 and the block is not yet drained. Strobes at any other time leave `rd_addr` and `dout` unchanged.
- R4: Each internal read loads `dout` with `rd_data` at the current address. The k-th enabled strobe after `data_avail` rises leaves result k-1 in `dout`, so the first enabled strobe is the priming strobe for result 0.
- R5: `bus_oe` is 1 exactly while `data_avail` and `dump_en` are both 1.
- R6: With `cfg_hold_dav` = 0, `data_avail` stays 1 through all N reads and drops on the next enabled strobe.
- R7: With `cfg_hold_dav` = 1, enabled strobes after the block is drained leave `data_avail` at 1. A `load_in` edge of the selected polarity then drops it: rising when `cfg_load_rise` = 1, falling when it is 0. An edge of the other polarity has no effect.
- R8: A `load_in` edge that arrives before all N results have been read leaves `data_avail` at 1.
- R9: `tag_oe` is 1 only while `bus_oe` is 1 and at least one read of the current block has happened. `tag_out` does not change while `data_avail` stays 1.
- R10: After the read at address N-1 (N = `N_RESULTS`, 256 or 1024), `rd_addr` wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dump_en | input | 1 | Dump enable from host, active high |
| out_strobe | input | 1 | Output strobe, asynchronous |
| load_in | input | 1 | Load edge input, asynchronous |
| cfg_hold_dav | input | 1 | 1: keep data-available until a load edge |
| cfg_load_rise | input | 1 | 1: rising load edge counts, 0: falling |
| blk_ready | input | 1 | One-cycle pulse: a result block is ready |
| blk_tag | input | 4 | Scale tag of the ready block |
| rd_data | input | DW | Result memory read data at `rd_addr` |
| rd_addr | output | AW | Result memory read address |
| rd_en | output | 1 | Internal read pulse |
| data_avail | output | 1 | Data-available flag |
| bus_oe | output | 1 | Data bus driver enable |
| dout | output | DW | Output data register |
| tag_out | output | 4 | Held scale tag |
| tag_oe | output | 1 | Scale tag driver enable |

## Verification
The bench interleaves strobes that have `dump_en` low with enabled ones. A design that counted raw strobes would run its address ahead and present the wrong result after the priming strobe. The final-transfer strobe is exercised under both settings of the hold bit. A design that dropped `data_avail` on the last fetch instead of the strobe after it would lose the last result, and one that ignored the hold bit would drop early. Load edges are sent before the block is drained and with the wrong polarity; a design that reacted to either would end the dump too soon. A second `blk_ready` in mid-block checks that the held scale tag cannot be overwritten.

// File: rtl/dump_pkg.sv
package dump_pkg;
  localparam int TAG_W = 4;

  // Next read index with wrap at block end.
  function automatic int unsigned next_index(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/dump_edge_sync.sv
module dump_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  input  logic pol_rise,
  output logic ev
);
  localparam int SW = STAGES + 1;
  logic [SW-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SW-2:0], d_async};
  end

  assign ev = pol_rise ? (sh[SW-2] & ~sh[SW-1]) : (~sh[SW-2] & sh[SW-1]);

  // R3: one input edge yields a single-cycle event
  p_ev_single_r3: assert property (@(posedge clk) disable iff (!rst_n) ev |=> !ev);
endmodule

// File: rtl/dump_addr_gen.sv
module dump_addr_gen #(
  parameter int N_RESULTS = 256,
  localparam int AW = $clog2(N_RESULTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          wrap
);
  import dump_pkg::*;

  assign wrap = step && (int'(addr) == N_RESULTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (clr)  addr <= '0;
    else if (step) addr <= AW'(next_index(int'(addr), N_RESULTS));
  end

  // R3: address moves only on a step or a clear
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(addr));
  // R10: wrap to zero after the last index
  p_addr_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !clr) |=> (addr == '0));
endmodule

// File: rtl/dump_port_ctrl.sv
module dump_port_ctrl #(
  parameter int N_RESULTS = 256,
  parameter int DW = 16,
  localparam int AW = $clog2(N_RESULTS),
  localparam int TW = dump_pkg::TAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dump_en,
  input  logic          out_strobe,
  input  logic          load_in,
  input  logic          cfg_hold_dav,
  input  logic          cfg_load_rise,
  input  logic          blk_ready,
  input  logic [TW-1:0] blk_tag,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          rd_en,
  output logic          data_avail,
  output logic          bus_oe,
  output logic [DW-1:0] dout,
  output logic [TW-1:0] tag_out,
  output logic          tag_oe
);
  logic stb_ev, load_ev, wrap;
  logic drained, primed;
  logic final_xfer, dav_set, dav_clr;

  dump_edge_sync #(.STAGES(2)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .d_async(out_strobe), .pol_rise(1'b1), .ev(stb_ev));

  dump_edge_sync #(.STAGES(2)) u_load_sync (
    .clk(clk), .rst_n(rst_n), .d_async(load_in), .pol_rise(cfg_load_rise), .ev(load_ev));

  // Named internal events
  assign rd_en      = stb_ev && data_avail && dump_en && !drained;
  assign final_xfer = stb_ev && data_avail && dump_en && drained;
  assign dav_set    = blk_ready && !data_avail;
  assign dav_clr    = (final_xfer && !cfg_hold_dav) ||
                      (load_ev && cfg_hold_dav && data_avail && drained);

  dump_addr_gen #(.N_RESULTS(N_RESULTS)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(dav_set), .step(rd_en), .addr(rd_addr), .wrap(wrap));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_avail <= 1'b0;
      drained    <= 1'b0;
      primed     <= 1'b0;
      tag_out    <= '0;
      dout       <= '0;
    end else begin
      if (dav_set) begin
        data_avail <= 1'b1;
        drained    <= 1'b0;
        primed     <= 1'b0;
        tag_out    <= blk_tag;
      end else if (dav_clr) begin
        data_avail <= 1'b0;
        primed     <= 1'b0;
      end
      if (rd_en) begin
        dout   <= rd_data;
        primed <= 1'b1;
      end
      if (wrap) drained <= 1'b1;
    end
  end

  assign bus_oe = data_avail && dump_en;
  assign tag_oe = bus_oe && primed;

  // R2: new block always starts at address zero
  p_rise_addr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_avail) |-> (rd_addr == '0));
  // R6: data-available never drops before the block is drained
  p_fall_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_avail) |-> $past(drained));
  // R7: in hold mode only a load edge ends the block
  p_hold_needs_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(data_avail) && $past(cfg_hold_dav)) |-> $past(load_ev));
  // R9: tag constant while the block is available
  p_tag_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_avail && $past(data_avail)) |-> $stable(tag_out));
  // R9: tag enable implies data bus enable
  p_tag_with_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tag_oe |-> bus_oe);
endmodule

// File: tb/tb_dump_port_ctrl.sv
module tb_dump_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 256;
  localparam int DW = 16;
  localparam int AW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic dump_en = 0, out_strobe = 0, load_in = 0;
  logic cfg_hold_dav = 0, cfg_load_rise = 1, blk_ready = 0;
  logic [3:0] blk_tag = 0;
  logic [DW-1:0] rd_data, dout;
  logic [AW-1:0] rd_addr;
  logic rd_en, data_avail, bus_oe, tag_oe;
  logic [3:0] tag_out;

  int checks = 0, fails = 0, cycles = 0;
  int exp_addr = 0, exp_reads = 0;
  bit exp_dav = 0;
  logic [DW-1:0] exp_dout = 0;
  logic [3:0] exp_tag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] memval(input int a);
    return DW'((a * 40503 + 17) ^ 16'h5A3C);
  endfunction

  assign rd_data = memval(int'(rd_addr));

  dump_port_ctrl #(.N_RESULTS(N), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .dump_en(dump_en), .out_strobe(out_strobe),
    .load_in(load_in), .cfg_hold_dav(cfg_hold_dav), .cfg_load_rise(cfg_load_rise),
    .blk_ready(blk_ready), .blk_tag(blk_tag), .rd_data(rd_data), .rd_addr(rd_addr),
    .rd_en(rd_en), .data_avail(data_avail), .bus_oe(bus_oe), .dout(dout),
    .tag_out(tag_out), .tag_oe(tag_oe));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "rd_addr", rd_addr, exp_addr);
    chk(req, "dout", dout, exp_dout);
    chk(req, "data_avail", data_avail, exp_dav);
    chk("R5", "bus_oe", bus_oe, exp_dav && dump_en);
    chk("R9", "tag_oe", tag_oe, exp_dav && dump_en && exp_reads > 0);
    if (exp_dav) chk("R9", "tag_out", tag_out, exp_tag);
  endtask

  task automatic start_block(input logic [3:0] tag);
    @(negedge clk); blk_tag = tag; blk_ready = 1;
    @(negedge clk); blk_ready = 0;
    if (!exp_dav) begin
      exp_dav = 1; exp_addr = 0; exp_reads = 0; exp_tag = tag;
    end
    check_state("R2");
  endtask

  task automatic do_strobe(input bit en, input string req);
    @(negedge clk); dump_en = en; out_strobe = 1;
    repeat (4) @(negedge clk);
    out_strobe = 0;
    repeat (3) @(negedge clk);
    if (exp_dav && en) begin
      if (exp_reads < N) begin
        exp_dout = memval(exp_addr);
        exp_addr = (exp_addr + 1) % N;
        exp_reads++;
      end else if (!cfg_hold_dav) exp_dav = 0;
    end
    check_state(req);
  endtask

  task automatic do_load(input bit lvl, input string req);
    bit hit;
    @(negedge clk);
    hit = (lvl != load_in) && (lvl == cfg_load_rise);
    load_in = lvl;
    repeat (4) @(negedge clk);
    if (hit && cfg_hold_dav && exp_dav && exp_reads == N) exp_dav = 0;
    check_state(req);
  endtask

  task automatic run_block(input bit mid_retag);
    while (exp_reads < N) begin
      if (mid_retag && exp_reads == 100) start_block(~exp_tag);  // R2 ignored mid-block
      do_strobe(($urandom % 4) != 0, (exp_reads == N - 1) ? "R10" : "R4");
    end
    chk("R10", "rd_addr wrapped", rd_addr, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1");

    // Block A: hold clear
    start_block(4'h5);
    dump_en = 0; @(negedge clk); check_state("R5");
    do_strobe(1'b0, "R3");               // disabled strobe: no read
    cfg_hold_dav = 1;
    do_load(1'b1, "R8"); do_load(1'b0, "R8");   // load before drained
    cfg_hold_dav = 0;
    do_strobe(1'b1, "R4");               // priming strobe -> result 0
    run_block(1'b1);
    do_strobe(1'b0, "R6");               // disabled final strobe: still available
    do_strobe(1'b1, "R6");               // final transfer drops flag
    do_strobe(1'b1, "R3");               // strobe while idle: no effect

    // Block B: hold set, rising load edge
    cfg_hold_dav = 1; cfg_load_rise = 1;
    start_block(4'h9);
    run_block(1'b0);
    do_strobe(1'b1, "R7"); do_strobe(1'b1, "R7");
    do_load(1'b1, "R7");
    do_load(1'b0, "R7");

    // Block C: hold set, falling load edge
    cfg_load_rise = 0;
    start_block(4'hC);
    run_block(1'b0);
    do_strobe(1'b1, "R7");
    do_load(1'b1, "R7");                 // wrong polarity: stays
    do_load(1'b0, "R7");                 // selected polarity: drops

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end
endmodule